// File: doc/BRIEF.md
# Link-Side Status Transfer Deserializer

This block sits on the link side of a two-wire-control, two-wire-data PHY/link interface. The PHY sends a status word over several clocks. Each clock it holds the control lines at the status code and puts two status bits on the data lines. The block counts those status cycles and builds up the 16-bit status word. It reports two results at different points of a single transfer: the four event flags once the first two pairs have arrived, and the register read-back (4-bit address plus 8-bit contents) once all eight pairs have arrived.

The PHY may cut a transfer short by driving any other control code, for example when a packet starts to arrive. Flags that have already been captured are still delivered. A register payload that is only partly received is dropped, and the previous register outputs stay as they were. When a transfer ends at a length that is not a normal one, the block raises a one-clock abort strobe. The link logic can use that strobe to expect a retry.

Top module: `sts_status_deser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, flag_bits, reg_addr and reg_data are zero and flags_vld, reg_vld and abort_pulse are low.
- R2: A status cycle is any clock with ctl_in == 2'b01. On the k-th status cycle of a run (k counted from 0), dat_in[0] is status bit 2k and dat_in[1] is status bit 2k+1.
- R3: In the clock after the second status cycle of a run, flags_vld is high for exactly one clock and flag_bits equals status bits 3..0.
- R4: In the clock after the eighth status cycle of a run, reg_vld is high for exactly one clock, reg_addr equals status bits 7..4 and reg_data equals status bits 15..8.
- R5: If a run has at least two status cycles, its flags are delivered as in R3 even when the run ends before the eighth cycle. flag_bits keeps that value until the next flags_vld.
- R6: When a run ends with fewer than eight status cycles, reg_vld stays low and reg_addr and reg_data keep the values of the last completed register transfer.
- R7: In the clock after the first non-status cycle that ends a run of 1, 3 to 7, or more than 8 status cycles, abort_pulse is high for exactly one clock. A run of exactly 2 or 8 cycles raises no abort. A run longer than 8 cycles still delivers flags and register, and the extra pairs are ignored.
- R8: Any non-status code (00, 10 or 11) ends a run. The next run starts capturing at bit 0 again, whatever the length of the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ctl_in | input | 2 | Control code from the PHY; 2'b01 marks a status cycle |
| dat_in | input | 2 | Status bit pair; bit 0 is the lower-indexed status bit |
| flag_bits | output | 4 | Last delivered event flags (status bits 3..0) |
| flags_vld | output | 1 | One-clock strobe: flag_bits has just been updated |
| reg_addr | output | 4 | Address of the last completed register read-back |
| reg_data | output | 8 | Contents of the last completed register read-back |
| reg_vld | output | 1 | One-clock strobe: reg_addr and reg_data have just been updated |
| abort_pulse | output | 1 | One-clock strobe: a run ended at an abnormal length |

## Verification
If the pair counter is wrong, bits land in the wrong positions. That shows up as bad flag or register values in the very next strobe. It also shows up as strobes one clock early or late, or as an abort where none is due. A counter that fails to clear between runs corrupts the first transfer after an interrupted one, and that is visible within the eight cycles of that transfer. A register output that updates on a partial transfer is exposed by reading reg_addr and reg_data straight after a cut-short run, before any further complete transfer.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE     = 2'b00,
    CTL_STATUS   = 2'b01,
    CTL_RECEIVE  = 2'b10,
    CTL_TRANSMIT = 2'b11
  } ctl_code_e;
endpackage

// File: rtl/sts_pair_counter.sv
module sts_pair_counter #(
  parameter int FLAG_PAIRS = 2,
  parameter int WORD_PAIRS = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_cyc,
  output logic [CNT_W-1:0] cnt,
  output logic             flags_done,
  output logic             reg_done,
  output logic             cut_short
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_PAIRS + 1);
  localparam logic [CNT_W-1:0] FLAG_END = CNT_W'(FLAG_PAIRS);
  localparam logic [CNT_W-1:0] WORD_END = CNT_W'(WORD_PAIRS);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = status_cyc ? (cnt_q != CNT_SAT) : (cnt_q != '0);
    cnt_nxt = status_cyc ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  always_comb begin
    cnt        = cnt_q;
    flags_done = status_cyc && (cnt_q == FLAG_END - 1'b1);
    reg_done   = status_cyc && (cnt_q == WORD_END - 1'b1);
    cut_short  = !status_cyc && (cnt_q != '0) &&
                 (cnt_q != FLAG_END) && (cnt_q != WORD_END);
  end
endmodule

// File: rtl/sts_word_capture.sv
module sts_word_capture #(
  parameter int WORD_PAIRS = 8,
  parameter int CNT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    status_cyc,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [1:0]              pair,
  output logic [2*WORD_PAIRS-1:0] word_live
);
  for (genvar k = 0; k < WORD_PAIRS; k++) begin : g_pair
    logic [1:0] slot_q, slot_nxt;
    logic       slot_en;

    always_comb begin
      slot_en  = status_cyc && (cnt == CNT_W'(k));
      slot_nxt = slot_en ? pair : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_nxt;
    end

    assign word_live[2*k +: 2] = slot_nxt;
  end
endmodule

// File: rtl/sts_result_regs.sv
module sts_result_regs #(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flags_done,
  input  logic              reg_done,
  input  logic              cut_short,
  input  logic [WORD_W-1:0] word_live,
  output logic [FLAG_W-1:0] flag_bits,
  output logic              flags_vld,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              reg_vld,
  output logic              abort_pulse
);
  localparam int ADDR_LSB = FLAG_W;
  localparam int DATA_LSB = FLAG_W + ADDR_W;

  logic [FLAG_W-1:0] flags_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    flags_nxt = word_live[0 +: FLAG_W];
    addr_nxt  = word_live[ADDR_LSB +: ADDR_W];
    data_nxt  = word_live[DATA_LSB +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_bits <= '0;
    else if (flags_done) flag_bits <= flags_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr <= '0;
      reg_data <= '0;
    end else if (reg_done) begin
      reg_addr <= addr_nxt;
      reg_data <= data_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_vld   <= 1'b0;
      reg_vld     <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      flags_vld   <= flags_done;
      reg_vld     <= reg_done;
      abort_pulse <= cut_short;
    end
  end
endmodule

// File: rtl/sts_status_deser.sv
module sts_status_deser #(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_in,
  input  logic [1:0]        dat_in,
  output logic [FLAG_W-1:0] flag_bits,
  output logic              flags_vld,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              reg_vld,
  output logic              abort_pulse
);
  import sts_pkg::*;

  localparam int WORD_W     = FLAG_W + ADDR_W + DATA_W;
  localparam int WORD_PAIRS = WORD_W / 2;
  localparam int FLAG_PAIRS = FLAG_W / 2;
  localparam int CNT_W      = $clog2(WORD_PAIRS + 2);

  logic             status_cyc;
  logic [CNT_W-1:0] cnt;
  logic             flags_done, reg_done, cut_short;
  logic [WORD_W-1:0] word_live;

  assign status_cyc = (ctl_in == CTL_STATUS);

  sts_pair_counter #(
    .FLAG_PAIRS(FLAG_PAIRS), .WORD_PAIRS(WORD_PAIRS), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .status_cyc(status_cyc), .cnt(cnt),
    .flags_done(flags_done), .reg_done(reg_done), .cut_short(cut_short)
  );

  sts_word_capture #(
    .WORD_PAIRS(WORD_PAIRS), .CNT_W(CNT_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .status_cyc(status_cyc), .cnt(cnt),
    .pair(dat_in), .word_live(word_live)
  );

  sts_result_regs #(
    .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .flags_done(flags_done), .reg_done(reg_done),
    .cut_short(cut_short), .word_live(word_live),
    .flag_bits(flag_bits), .flags_vld(flags_vld),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_vld(reg_vld),
    .abort_pulse(abort_pulse)
  );
endmodule

// File: rtl/sts_deser_chk.sv
module sts_deser_chk #(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctl_in,
  input logic [FLAG_W-1:0] flag_bits,
  input logic              flags_vld,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_data,
  input logic              reg_vld,
  input logic              abort_pulse
);
  // R3
  flags_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_vld |=> !flags_vld);
  // R3
  flags_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_vld |-> $past(ctl_in) == 2'b01);
  // R4
  reg_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_vld |-> $past(ctl_in) == 2'b01);
  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_vld |-> $stable(flag_bits));
  // R6
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_vld |-> ($stable(reg_addr) && $stable(reg_data)));
  // R7
  abort_after_nonstatus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(ctl_in) != 2'b01);
  // R7
  abort_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags_vld, reg_vld, abort_pulse}));
endmodule

bind sts_status_deser sts_deser_chk #(
  .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_sts_status_deser.sv
module tb_sts_status_deser;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    int          kind;   // 0 flags, 1 register, 2 abort
    logic [11:0] val;
    string       tag;
  } exp_item_t;

  logic       clk, rst_n;
  logic [1:0] ctl_in, dat_in;
  logic [3:0] flag_bits;
  logic       flags_vld;
  logic [3:0] reg_addr;
  logic [7:0] reg_data;
  logic       reg_vld, abort_pulse;

  int checks = 0;
  int errors = 0;
  bit monitor_on = 0;
  exp_item_t sb[$];

  sts_status_deser dut (
    .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .dat_in(dat_in),
    .flag_bits(flag_bits), .flags_vld(flags_vld),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_vld(reg_vld),
    .abort_pulse(abort_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [11:0] val, input string tag);
    exp_item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  // Drive one run of ncyc status cycles carrying word, ended by code endc.
  task automatic xfer(input logic [15:0] word, input int ncyc,
                      input logic [1:0] endc, input string tag);
    if (ncyc >= 2) push(0, {8'h0, word[3:0]}, tag);
    if (ncyc >= 8) push(1, word[15:4], tag);
    if (ncyc != 2 && ncyc != 8) push(2, 12'h0, tag);
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk); #1;
      ctl_in = 2'b01;
      dat_in = (k < 8) ? word[2*k +: 2] : 2'b00;
    end
    @(posedge clk); #1;
    ctl_in = endc; dat_in = 2'b00;
    @(posedge clk); #1;
    ctl_in = 2'b00;
    @(posedge clk); #1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (monitor_on) begin
      int n;
      n = int'(flags_vld) + int'(reg_vld) + int'(abort_pulse);
      if (n > 1) check(1'b0, "R7 strobe overlap", 16'(n), 16'd1);
      else if (n == 1) begin
        if (sb.size() == 0) check(1'b0, "R7 unexpected strobe",
                                  {13'h0, abort_pulse, reg_vld, flags_vld}, 16'h0);
        else begin
          exp_item_t it;
          it = sb.pop_front();
          if (it.kind == 0)
            check(flags_vld && flag_bits == it.val[3:0], {it.tag, " R3 flags"},
                  {11'h0, flags_vld, flag_bits}, {11'h0, 1'b1, it.val[3:0]});
          else if (it.kind == 1)
            check(reg_vld && {reg_data, reg_addr} == it.val, {it.tag, " R4 register"},
                  {3'h0, reg_vld, reg_data, reg_addr}, {3'h0, 1'b1, it.val});
          else
            check(abort_pulse == 1'b1, {it.tag, " R7 abort"},
                  {13'h0, abort_pulse, reg_vld, flags_vld}, 16'h4);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_in = 2'b00; dat_in = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check({flag_bits, flags_vld, reg_addr, reg_data, reg_vld, abort_pulse} == '0,
          "R1 reset outputs", {flag_bits, reg_addr, reg_data}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({flag_bits, flags_vld, reg_addr, reg_data, reg_vld, abort_pulse} == '0,
          "R1 after release", {flag_bits, reg_addr, reg_data}, 16'h0);
    monitor_on = 1;
    @(posedge clk); #1;

    xfer(16'hA5C3, 8, 2'b00, "R4");
    xfer(16'h0009, 2, 2'b00, "R3");
    xfer(16'h8001, 8, 2'b00, "R2");
    xfer(16'h1234, 5, 2'b10, "R5");
    // R6 partial register discarded, R5 flags held
    @(negedge clk);
    check({reg_data, reg_addr} == 12'h800, "R6 register hold",
          {4'h0, reg_data, reg_addr}, 16'h0800);
    check(flag_bits == 4'h4, "R5 flags kept", {12'h0, flag_bits}, 16'h4);
    @(posedge clk); #1;
    xfer(16'hFFFF, 1, 2'b10, "R7");
    xfer(16'h7E81, 8, 2'b11, "R8");
    xfer(16'h5A5A, 9, 2'b00, "R7");
    xfer(16'h0F06, 3, 2'b10, "R6");
    @(negedge clk);
    check({reg_data, reg_addr} == 12'h5A5, "R6 register hold after cut",
          {4'h0, reg_data, reg_addr}, 16'h05A5);
    @(posedge clk); #1;
    xfer(16'h3C96, 7, 2'b11, "R6");
    xfer(16'h6B2D, 8, 2'b00, "R8");
    xfer(16'h0002, 2, 2'b11, "R2");
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R7 missing strobes", 16'(sb.size()), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule